// File: doc/BRIEF.md
# Floating-Point Issue Scoreboard

This block sits in the decode stage in front of three independent floating-point execution units: an adder, a multiplier and a divider. Each cycle it looks at the operation waiting in decode and decides whether to let it start or hold it. Operations leave decode in program order, but they may finish in any order, because the units have different latencies and can run side by side.

Hazards are handled by stalling, with no forwarding and no renaming. One busy flag per unit covers structural conflicts. One busy flag per register, set for the destination of every operation in flight, covers read-after-write and write-after-write conflicts. Each unit holds a down-counter loaded with the operation latency at issue. The unit raises a one-cycle writeback pulse in its last cycle, and both flags drop at the end of that cycle. Rounding hardware is shared, so only one writeback may happen per cycle. Issue is therefore held back whenever the new operation would finish in the same cycle as one already running.

Decode presents an operation with `in_valid`. The operation is taken at a rising edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, decode must hold the operation stable. `in_ready` depends only on the operation's fields and the block's state, never on `in_valid`. A stalled operation is re-evaluated every cycle and is taken in the first cycle with no hazard.

Top module: `fp_issue_scoreboard`

## Requirements
- R1: After reset, every unit flag and every register flag is clear and there is no writeback. An add, multiply or divide presented in the first cycle is ready.
- R2: Unit codes are 0 add, 1 multiply, 2 divide. For an operation taken at the end of cycle c, `wb_valid` is high in cycle c+L only, where L is the latency below.
  - Add: L = 2 for both precisions.
  - Multiply: L = 4 for single (`in_dbl`=0) and 5 for double.
  - Divide: L = 12 for single and 19 for double.
- R3: `in_ready` is low while the requested unit is busy. A unit is busy from the cycle after issue through its writeback cycle.
- R4: `in_ready` is low while the register flag of either source is set.
- R5: `in_ready` is low while the register flag of the destination is set.
- R6: `in_ready` is low when another running unit would raise its writeback in the same cycle as the candidate operation.
- R7: At most one unit writes back per cycle. `wb_unit` and `wb_reg` name that unit and the destination of its operation.
- R8: Taking an operation sets its unit flag and its destination register flag from the next cycle on. Both flags clear in the cycle after that operation's writeback.
- R9: Unit code 3 is reserved and never has `in_ready` high.
- R10: An operation for an idle unit with no register or writeback conflict is ready even while other units are busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decode holds an operation |
| in_ready | output | 1 | Operation may issue this cycle |
| in_unit | input | 2 | Unit code: 0 add, 1 multiply, 2 divide, 3 reserved |
| in_dbl | input | 1 | 1 for double precision |
| in_src_a | input | 5 | First source register |
| in_src_b | input | 5 | Second source register |
| in_dst | input | 5 | Destination register |
| wb_valid | output | 1 | A unit writes back this cycle |
| wb_unit | output | 2 | Unit writing back |
| wb_reg | output | 5 | Destination being written |
| unit_busy | output | 3 | Unit flags, bit index = unit code |
| reg_busy | output | 32 | Register flags, bit index = register number |

## Verification
`in_ready` is combinational, so it is due in the same cycle the operation is presented. The bench drives each operation just after a falling edge and compares 1 ns later, well before the next rising edge. Flags and writeback come from registers, so they are due in the cycles after the edge that took the operation: the flags from the next cycle, and the writeback pulse exactly L cycles later. The bench's behavioural model advances its own latency counts only at the rising edge and checks them in every cycle. The directed latency checks count whole cycles from the issuing edge to the first observed pulse.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;
  localparam int NUNITS = 3;
  typedef enum logic [1:0] {
    U_ADD = 2'd0,
    U_MUL = 2'd1,
    U_DIV = 2'd2,
    U_RSV = 2'd3
  } unit_e;
endpackage

// File: rtl/fpsb_unit_timer.sv
module fpsb_unit_timer #(
  parameter int CW = 5,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_lat,
  input  logic [RW-1:0] start_dst,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] dst,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dst <= '0;
    end else if (start) begin
      cnt <= start_lat;
      dst <= start_dst;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/fpsb_reg_flags.sv
module fpsb_reg_flags #(
  parameter int NREG = 32,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [RW-1:0]   set_idx,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_idx,
  output logic [NREG-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (set_en && (RW'(i) == set_idx))
          flags[i] <= 1'b1;
        else if (clr_en && (RW'(i) == clr_idx))
          flags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpsb_issue_check.sv
module fpsb_issue_check
  import fpsb_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int RW    = 5,
  parameter int CW    = 5,
  parameter int LAT_ADD = 2,
  parameter int LAT_MS  = 4,
  parameter int LAT_MD  = 5,
  parameter int LAT_DS  = 12,
  parameter int LAT_DD  = 19
) (
  input  logic [1:0]                   unit,
  input  logic                         dbl,
  input  logic [RW-1:0]                src_a,
  input  logic [RW-1:0]                src_b,
  input  logic [RW-1:0]                dst,
  input  logic [NREG-1:0]              reg_busy,
  input  logic [NUNITS-1:0]            unit_busy,
  input  logic [NUNITS-1:0][CW-1:0]    cnt,
  output logic                         ready,
  output logic [CW-1:0]                lat
);
  logic rsv, ubusy, clash, reg_hit;

  always_comb begin
    case (unit_e'(unit))
      U_ADD:   lat = CW'(LAT_ADD);
      U_MUL:   lat = dbl ? CW'(LAT_MD) : CW'(LAT_MS);
      U_DIV:   lat = dbl ? CW'(LAT_DD) : CW'(LAT_DS);
      default: lat = '0;
    endcase
  end

  always_comb begin
    rsv   = (unit_e'(unit) == U_RSV);
    ubusy = 1'b0;
    clash = 1'b0;
    for (int u = 0; u < NUNITS; u++) begin
      if (int'(unit) == u) begin
        ubusy = unit_busy[u];
      end else if (cnt[u] == (lat + CW'(1))) begin
        clash = 1'b1;
      end
    end
    reg_hit = reg_busy[src_a] | reg_busy[src_b] | reg_busy[dst];
    ready   = !rsv && !ubusy && !reg_hit && !clash;
  end
endmodule

// File: rtl/fp_issue_scoreboard.sv
module fp_issue_scoreboard
  import fpsb_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int LAT_ADD = 2,
  parameter int LAT_MS  = 4,
  parameter int LAT_MD  = 5,
  parameter int LAT_DS  = 12,
  parameter int LAT_DD  = 19
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                in_unit,
  input  logic                      in_dbl,
  input  logic [$clog2(NREG)-1:0]   in_src_a,
  input  logic [$clog2(NREG)-1:0]   in_src_b,
  input  logic [$clog2(NREG)-1:0]   in_dst,
  output logic                      wb_valid,
  output logic [1:0]                wb_unit,
  output logic [$clog2(NREG)-1:0]   wb_reg,
  output logic [NUNITS-1:0]         unit_busy,
  output logic [NREG-1:0]           reg_busy
);
  localparam int RW     = $clog2(NREG);
  localparam int MAXLAT = LAT_DD + 2;
  localparam int CW     = $clog2(MAXLAT + 1);

  logic                      fire;
  logic [CW-1:0]             new_lat;
  logic [NUNITS-1:0]         done_vec;
  logic [NUNITS-1:0]         start_vec;
  logic [NUNITS-1:0][CW-1:0] cnt;
  logic [NUNITS-1:0][RW-1:0] udst;

  fpsb_issue_check #(
    .NREG(NREG), .RW(RW), .CW(CW),
    .LAT_ADD(LAT_ADD), .LAT_MS(LAT_MS), .LAT_MD(LAT_MD),
    .LAT_DS(LAT_DS), .LAT_DD(LAT_DD)
  ) check_i (
    .unit(in_unit), .dbl(in_dbl), .src_a(in_src_a), .src_b(in_src_b),
    .dst(in_dst), .reg_busy(reg_busy), .unit_busy(unit_busy), .cnt(cnt),
    .ready(in_ready), .lat(new_lat)
  );

  assign fire = in_valid && in_ready;

  for (genvar g = 0; g < NUNITS; g++) begin : g_unit
    assign start_vec[g] = fire && (int'(in_unit) == g);
    fpsb_unit_timer #(.CW(CW), .RW(RW)) timer_i (
      .clk(clk), .rst_n(rst_n),
      .start(start_vec[g]), .start_lat(new_lat), .start_dst(in_dst),
      .busy(unit_busy[g]), .done(done_vec[g]), .dst(udst[g]), .cnt(cnt[g])
    );
  end

  always_comb begin
    wb_unit = 2'd0;
    wb_reg  = '0;
    for (int u = NUNITS - 1; u >= 0; u--) begin
      if (done_vec[u]) begin
        wb_unit = 2'(u);
        wb_reg  = udst[u];
      end
    end
  end
  assign wb_valid = |done_vec;

  fpsb_reg_flags #(.NREG(NREG), .RW(RW)) flags_i (
    .clk(clk), .rst_n(rst_n),
    .set_en(fire), .set_idx(in_dst),
    .clr_en(wb_valid), .clr_idx(wb_reg),
    .flags(reg_busy)
  );
endmodule

// File: rtl/fpsb_checker.sv
module fpsb_checker #(
  parameter int NREG = 32,
  parameter int RW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      in_unit,
  input logic [RW-1:0]   in_src_a,
  input logic [RW-1:0]   in_src_b,
  input logic [RW-1:0]   in_dst,
  input logic            wb_valid,
  input logic [RW-1:0]   wb_reg,
  input logic [2:0]      unit_busy,
  input logic [2:0]      done_vec,
  input logic [NREG-1:0] reg_busy
);
  logic [3:0] ubusy_x;
  assign ubusy_x = {1'b0, unit_busy};

  a_r3_unit_block: assert property (@(posedge clk) disable iff (!rst_n)
    ubusy_x[in_unit] |-> !in_ready);
  a_r4_src_block: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_busy[in_src_a] || reg_busy[in_src_b]) |-> !in_ready);
  a_r5_dst_block: assert property (@(posedge clk) disable iff (!rst_n)
    reg_busy[in_dst] |-> !in_ready);
  a_r7_single_wb: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec));
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> reg_busy[$past(in_dst)]);
  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !reg_busy[$past(wb_reg)]);
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_unit == 2'd3) |-> !in_ready);
endmodule

bind fp_issue_scoreboard fpsb_checker #(.NREG(NREG), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_unit(in_unit), .in_src_a(in_src_a), .in_src_b(in_src_b),
  .in_dst(in_dst), .wb_valid(wb_valid), .wb_reg(wb_reg),
  .unit_busy(unit_busy), .done_vec(done_vec), .reg_busy(reg_busy)
);

// File: tb/fp_issue_scoreboard_tb.sv
`timescale 1ns/1ps
module fp_issue_scoreboard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_unit = 2'd0;
  logic        in_dbl = 1'b0;
  logic [4:0]  in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic        wb_valid;
  logic [1:0]  wb_unit;
  logic [4:0]  wb_reg;
  logic [2:0]  unit_busy;
  logic [31:0] reg_busy;

  always #2.5 clk = ~clk;

  fp_issue_scoreboard dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_unit(in_unit), .in_dbl(in_dbl), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_dst(in_dst), .wb_valid(wb_valid),
    .wb_unit(wb_unit), .wb_reg(wb_reg), .unit_busy(unit_busy),
    .reg_busy(reg_busy)
  );

  int n_checks = 0, n_fail = 0;
  bit done_flag = 0;
  int rem [3];
  int mdst [3];
  bit rb [32];
  bit obs_ready, obs_wb;

  function automatic int lat_of(int u, bit d);
    if (u == 0) return 2;
    if (u == 1) return d ? 5 : 4;
    if (u == 2) return d ? 19 : 12;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input int u, input bit d, input int a,
                      input int b, input int dd, output bit issued);
    bit er, ew;
    int ewr, ewu, l;
    logic [31:0] erb;
    logic [2:0] eub;
    @(negedge clk);
    in_valid = v; in_unit = 2'(u); in_dbl = d;
    in_src_a = 5'(a); in_src_b = 5'(b); in_dst = 5'(dd);
    #1;
    l = lat_of(u, d);
    er = (u < 3) && (rem[u] == 0) && !rb[a] && !rb[b] && !rb[dd];
    for (int k = 0; k < 3; k++)
      if (k != u && rem[k] == l + 1) er = 0;
    ew = 0; ewr = 0; ewu = 0;
    for (int k = 0; k < 3; k++)
      if (rem[k] == 1) begin ew = 1; ewr = mdst[k]; ewu = k; end
    for (int k = 0; k < 32; k++) erb[k] = rb[k];
    for (int k = 0; k < 3; k++) eub[k] = (rem[k] != 0);
    chk(in_ready === er, "R3/R4/R5/R6/R9/R10 ready", in_ready, er);
    chk(wb_valid === ew, "R2/R7 wb_valid", wb_valid, ew);
    if (ew) begin
      chk(wb_reg === 5'(ewr), "R7 wb_reg", wb_reg, ewr);
      chk(wb_unit === 2'(ewu), "R7 wb_unit", wb_unit, ewu);
    end
    chk(reg_busy === erb, "R8 reg_busy", reg_busy, erb);
    chk(unit_busy === eub, "R8 unit_busy", unit_busy, eub);
    obs_ready = in_ready; obs_wb = wb_valid;
    issued = v && er;
    @(posedge clk);
    for (int k = 0; k < 3; k++)
      if (rem[k] > 0) begin
        if (rem[k] == 1) rb[mdst[k]] = 0;
        rem[k]--;
      end
    if (issued) begin
      rem[u] = l; mdst[u] = dd; rb[dd] = 1;
    end
  endtask

  task automatic idle(int n);
    bit x;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, x);
  endtask

  task automatic latency_case(int u, bit d, int dd);
    bit iss;
    int n;
    iss = 0;
    for (int i = 0; i < 60 && !iss; i++) step(1, u, d, 30, 31, dd, iss);
    n = 0;
    do begin
      bit x;
      step(0, 0, 0, 0, 0, 0, x);
      n++;
    end while (!obs_wb && n < 40);
    chk(n == lat_of(u, d), "R2 latency", n, lat_of(u, d));
    idle(2);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    bit iss;
    for (int k = 0; k < 3; k++) begin rem[k] = 0; mdst[k] = 0; end
    for (int k = 0; k < 32; k++) rb[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(reg_busy === 32'd0, "R1 reg flags", reg_busy, 0);
    chk(unit_busy === 3'd0, "R1 unit flags", unit_busy, 0);
    chk(wb_valid === 1'b0, "R1 no wb", wb_valid, 0);
    // R1: first operation is ready
    step(1, 1, 0, 1, 2, 3, iss);
    chk(obs_ready == 1, "R1 first ready", obs_ready, 1);
    idle(6);

    latency_case(0, 0, 1);
    latency_case(0, 1, 2);
    latency_case(1, 0, 3);
    latency_case(1, 1, 4);
    latency_case(2, 0, 5);
    latency_case(2, 1, 6);

    // R3: structural
    step(1, 1, 1, 10, 11, 1, iss);
    step(1, 1, 0, 12, 13, 2, iss);
    chk(obs_ready == 0, "R3 unit busy", obs_ready, 0);
    idle(8);
    // R10: concurrency
    step(1, 2, 1, 10, 11, 5, iss);
    step(1, 0, 0, 12, 13, 6, iss);
    chk(obs_ready == 1, "R10 concurrent issue", obs_ready, 1);
    idle(25);
    // R4: RAW
    step(1, 0, 0, 10, 11, 7, iss);
    step(1, 1, 0, 7, 12, 13, iss);
    chk(obs_ready == 0, "R4 source busy", obs_ready, 0);
    idle(8);
    // R5: WAW
    step(1, 1, 1, 10, 11, 8, iss);
    step(1, 0, 0, 9, 10, 8, iss);
    chk(obs_ready == 0, "R5 dest busy", obs_ready, 0);
    idle(8);
    // R6: writeback clash
    step(1, 2, 0, 10, 11, 11, iss);
    idle(6);
    step(1, 1, 1, 13, 14, 12, iss);
    chk(obs_ready == 0, "R6 clash stall", obs_ready, 0);
    step(1, 1, 1, 13, 14, 12, iss);
    chk(obs_ready == 1, "R6 clash cleared", obs_ready, 1);
    idle(25);
    // R9: reserved code
    step(1, 3, 0, 1, 2, 3, iss);
    chk(obs_ready == 0, "R9 reserved", obs_ready, 0);
    idle(2);

    // mixed traffic, held until taken
    begin
      bit v = 0, d = 0;
      int u = 0, a = 0, b = 0, dd = 0;
      for (int i = 0; i < 4000; i++) begin
        if (!v || iss) begin
          v = ($urandom_range(9) < 7);
          u = ($urandom_range(19) == 0) ? 3 : $urandom_range(2);
          d = 1'($urandom_range(1));
          a = $urandom_range(7); b = $urandom_range(7); dd = $urandom_range(7);
        end
        step(v, u, d, a, b, dd, iss);
        if (u == 3 && v && i % 50 == 0) begin
          v = 0; iss = 1;
        end
      end
    end
    idle(25);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule